// File: doc/BRIEF.md
# I2C Interrupt Code Register

This block sits between the bit-level I2C master and slave engines and the CPU. Each engine raises single-cycle event pulses with a small cause code. The block turns every accepted event into one 4-bit interrupt code. Only one code is shown at a time, in a read-to-clear status register. A single `irq` line is high whenever a code is shown.

Events that arrive while a code is shown wait in a four-entry queue. A status read clears the shown code. The next waiting code is then promoted, but only after `irq` has been low for at least one cycle. The queue has a sticky loss flag that records any event dropped because the queue was full.

A second read address returns receive data. It gives the byte latched when a receive-data code was promoted, and that byte stays until it is read once. At any other time the same address returns the live shift register value. Promoting the slave "not acknowledged by master" code sends a one-cycle pulse that clears the transmit data register.

Top module: `irq_code_status`

## Requirements
- R1: After reset `irq` and `txClr` are low and a status read returns 0x00.
- R2: A master event with cause m in 1..5 is reported as code m. A slave event with cause s in 0..2 is reported as code 8+s. The code is visible, with `irq` high, in the cycle after the clock edge that follows the edge sampling the event.
- R3: A master cause of 0, 6 or 7 and a slave cause of 3 are ignored. Codes 0x6, 0x7 and codes above 0xA never appear.
- R4: A read with `regRd`=1 and `regSel`=0 returns {overflow, 3'b000, code} in bits [7:0]. It clears the code at that edge, so `irq` is low in the next cycle.
- R5: Waiting codes are promoted in arrival order, with the master event before the slave event of the same cycle. A shown code stays unchanged until it is read, and `irq` is low for at least one cycle between successive codes.
- R6: Up to four codes wait behind the shown one. An event that finds the queue full is dropped and sets status bit 7. That bit stays set until the next status read clears it.
- R7: A read with `regSel`=1 returns the byte that was on `shiftIn` when code 0x4 was promoted. It does so while that byte is latched; otherwise it returns the live `shiftIn` value.
- R8: A receive-data read (`regRd`=1, `regSel`=1) releases the latched byte, so later reads return the live `shiftIn`.
- R9: `txClr` pulses high for exactly one cycle, in the first cycle in which code 0xA is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| mstEvt | input | 1 | Master engine event strobe |
| mstCode | input | 3 | Master event cause (1..5 valid) |
| slvEvt | input | 1 | Slave engine event strobe |
| slvCode | input | 2 | Slave event cause (0..2 valid) |
| shiftIn | input | 8 | Live receive shift register contents |
| regRd | input | 1 | Register read strobe, acts at the clock edge |
| regSel | input | 1 | 0 = status register, 1 = receive data |
| rdData | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt request |
| txClr | output | 1 | One-cycle transmit-data clear pulse |

## Verification
An event is sampled at one clock edge and promoted at the next, so its code is checked one full cycle after the event strobe is removed. `rdData` is combinational and is sampled just after the read strobe is driven, before the clearing edge. The `irq` gap is checked in the cycle right after that edge, and the next code one cycle later. `txClr` is checked in the same cycle as the promoted 0xA and again one cycle after. All checks are taken on the falling clock edge, half a period away from every register update.

// File: rtl/irq_code_pkg.sv
package irq_code_pkg;
  localparam int STATUS_W = 8;
  localparam int CODE_W   = 4;

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t CODE_NONE   = 4'h0;
  localparam code_t CODE_RXDATA = 4'h4;
  localparam code_t SLAVE_BASE  = 4'h8;
  localparam code_t CODE_SNOACK = 4'hA;
  localparam logic [2:0] MST_MAX = 3'd5;
  localparam logic [1:0] SLV_BAD = 2'd3;

  typedef struct packed {
    logic pushM;
    logic pushS;
    logic pop;
    logic clrCode;
    logic setOvf;
    logic clrOvf;
    logic clrRx;
  } strobe_t;
endpackage

// File: rtl/irq_code_ctrl.sv
module irq_code_ctrl
  import irq_code_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             mstEvt,
  input  logic [2:0]       mstCode,
  input  logic             slvEvt,
  input  logic [1:0]       slvCode,
  input  logic             regRd,
  input  logic             regSel,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic             codeIdle,
  output strobe_t          stb
);
  logic mOk, sOk, statusRd;

  always_comb begin
    mOk      = mstEvt && (mstCode != 3'd0) && (mstCode <= MST_MAX);
    sOk      = slvEvt && (slvCode != SLV_BAD);
    statusRd = regRd && !regSel;

    stb.pushM   = mOk && (int'(fifoCount) < DEPTH);
    stb.pushS   = sOk && ((int'(fifoCount) + int'(stb.pushM)) < DEPTH);
    stb.setOvf  = (mOk && !stb.pushM) || (sOk && !stb.pushS);
    stb.pop     = codeIdle && (fifoCount != '0);
    stb.clrCode = statusRd;
    stb.clrOvf  = statusRd;
    stb.clrRx   = regRd && regSel;
  end
endmodule

// File: rtl/irq_code_dp.sv
module irq_code_dp
  import irq_code_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [2:0]          mstCode,
  input  logic [1:0]          slvCode,
  input  logic [7:0]          shiftIn,
  input  logic                regSel,
  output logic [CNT_W-1:0]    fifoCount,
  output logic                codeIdle,
  output code_t               code,
  output logic                ovf,
  output logic                irq,
  output logic                txClr,
  output logic [STATUS_W-1:0] rdData
);
  code_t           mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  code_t           mFull, sFull, head;
  logic [1:0]      nPush;
  logic            rxValid;
  logic [7:0]      rxByte;

  assign mFull    = {1'b0, mstCode};
  assign sFull    = SLAVE_BASE | {2'b00, slvCode};
  assign head     = mem[rdPtr];
  assign nPush    = {1'b0, stb.pushM} + {1'b0, stb.pushS};
  assign codeIdle = (code == CODE_NONE);
  assign irq      = !codeIdle;

  // queue storage: the master entry is written ahead of the slave entry
  always_ff @(posedge clk) begin
    if (stb.pushM) mem[wrPtr] <= mFull;
    if (stb.pushS) mem[stb.pushM ? wrPtr + PTR_W'(1) : wrPtr] <= sFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else begin
      wrPtr     <= wrPtr + PTR_W'(nPush);
      rdPtr     <= rdPtr + PTR_W'(stb.pop);
      fifoCount <= fifoCount + CNT_W'(nPush) - CNT_W'(stb.pop);
    end
  end

  // shown code; promotion only from an idle code gives the low irq cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      code    <= CODE_NONE;
      txClr   <= 1'b0;
      ovf     <= 1'b0;
      rxValid <= 1'b0;
      rxByte  <= '0;
    end else begin
      if (stb.pop)          code <= head;
      else if (stb.clrCode) code <= CODE_NONE;

      txClr <= stb.pop && (head == CODE_SNOACK);

      if (stb.setOvf)      ovf <= 1'b1;
      else if (stb.clrOvf) ovf <= 1'b0;

      if (stb.pop && head == CODE_RXDATA) begin
        rxValid <= 1'b1;
        rxByte  <= shiftIn;
      end else if (stb.clrRx) begin
        rxValid <= 1'b0;
      end
    end
  end

  always_comb begin
    if (regSel) rdData = rxValid ? rxByte : shiftIn;
    else        rdData = {ovf, 3'b000, code};
  end
endmodule

// File: rtl/irq_code_status.sv
module irq_code_status
  import irq_code_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       mstEvt,
  input  logic [2:0] mstCode,
  input  logic       slvEvt,
  input  logic [1:0] slvCode,
  input  logic [7:0] shiftIn,
  input  logic       regRd,
  input  logic       regSel,
  output logic [7:0] rdData,
  output logic       irq,
  output logic       txClr
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  strobe_t          stb;
  logic [CNT_W-1:0] fifoCount;
  logic             codeIdle;
  code_t            code;
  logic             ovf;

  irq_code_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .mstEvt(mstEvt), .mstCode(mstCode), .slvEvt(slvEvt), .slvCode(slvCode),
    .regRd(regRd), .regSel(regSel), .fifoCount(fifoCount),
    .codeIdle(codeIdle), .stb(stb)
  );

  irq_code_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .mstCode(mstCode), .slvCode(slvCode),
    .shiftIn(shiftIn), .regSel(regSel), .fifoCount(fifoCount),
    .codeIdle(codeIdle), .code(code), .ovf(ovf), .irq(irq),
    .txClr(txClr), .rdData(rdData)
  );
endmodule

// File: rtl/irq_code_checker.sv
module irq_code_checker (
  input logic       clk,
  input logic       rstN,
  input logic       regRd,
  input logic       regSel,
  input logic       irq,
  input logic       txClr,
  input logic [3:0] code,
  input logic       ovf
);
  // R4
  clear_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && !regSel && irq) |=> !irq);

  // R5
  code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (code != 4'h0 && !(regRd && !regSel)) |=> $stable(code));

  // R3
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (code != 4'h6) && (code != 4'h7) && (code <= 4'hA));

  // R9
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    txClr |=> !txClr);

  // R9
  tx_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    txClr |-> (code == 4'hA));

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !(regRd && !regSel)) |=> ovf);
endmodule

bind irq_code_status irq_code_checker u_chk (
  .clk(clk), .rstN(rstN), .regRd(regRd), .regSel(regSel),
  .irq(irq), .txClr(txClr), .code(code), .ovf(ovf)
);

// File: tb/test_irq_code_status.sv
module test_irq_code_status;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mstEvt = 1'b0;
  logic [2:0] mstCode = '0;
  logic       slvEvt = 1'b0;
  logic [1:0] slvCode = '0;
  logic [7:0] shiftIn = '0;
  logic       regRd = 1'b0;
  logic       regSel = 1'b0;
  logic [7:0] rdData;
  logic       irq, txClr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_code_status i_irq_code_status (
    .clk(clk), .rstN(rstN), .mstEvt(mstEvt), .mstCode(mstCode),
    .slvEvt(slvEvt), .slvCode(slvCode), .shiftIn(shiftIn),
    .regRd(regRd), .regSel(regSel), .rdData(rdData), .irq(irq), .txClr(txClr)
  );

  // {mstEvt, mstCode, slvEvt, slvCode, first code, second code}
  localparam logic [14:0] VEC [10] = '{
    {1'b1, 3'd1, 1'b0, 2'd0, 4'h1, 4'h0},
    {1'b1, 3'd2, 1'b0, 2'd0, 4'h2, 4'h0},
    {1'b1, 3'd3, 1'b0, 2'd0, 4'h3, 4'h0},
    {1'b1, 3'd5, 1'b0, 2'd0, 4'h5, 4'h0},
    {1'b0, 3'd0, 1'b1, 2'd0, 4'h8, 4'h0},
    {1'b0, 3'd0, 1'b1, 2'd1, 4'h9, 4'h0},
    {1'b1, 3'd4, 1'b1, 2'd2, 4'h4, 4'hA},
    {1'b1, 3'd6, 1'b1, 2'd1, 4'h9, 4'h0},
    {1'b1, 3'd0, 1'b1, 2'd3, 4'h0, 4'h0},
    {1'b1, 3'd7, 1'b1, 2'd0, 4'h8, 4'h0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
    end
  endtask

  // status read: sample before the clearing edge, release after it
  task automatic readStatus(input string req, input logic [7:0] exp);
    regRd = 1'b1; regSel = 1'b0;
    #1 chk(req, rdData, exp);
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic pulseEvt(input logic mv, input logic [2:0] mc, input logic sv, input logic [1:0] sc);
    mstEvt = mv; mstCode = mc; slvEvt = sv; slvCode = sc;
    @(negedge clk);
    mstEvt = 1'b0; slvEvt = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 txClr", {7'd0, txClr}, 8'h00);
    chk("R1 status", rdData, 8'h00);

    // vector table: R2, R3, R4, R5, R9
    foreach (VEC[i]) begin
      logic [3:0] e1, e2;
      e1 = VEC[i][7:4];
      e2 = VEC[i][3:0];
      pulseEvt(VEC[i][14], VEC[i][13:11], VEC[i][10], VEC[i][9:8]);
      @(negedge clk);
      chk("R2 irq first", {7'd0, irq}, {7'd0, e1 != 4'h0});
      readStatus("R2_R3 first code", {4'h0, e1});
      chk("R4 irq gap", {7'd0, irq}, 8'h00);
      @(negedge clk);
      chk("R5 irq second", {7'd0, irq}, {7'd0, e2 != 4'h0});
      chk("R9 txClr", {7'd0, txClr}, {7'd0, e2 == 4'hA});
      readStatus("R5 second code", {4'h0, e2});
      chk("R9 txClr single", {7'd0, txClr}, 8'h00);
      @(negedge clk);
    end

    // R5 order and R6 overflow: m1 shown, four queued, sixth dropped
    pulseEvt(1'b1, 3'd1, 1'b0, 2'd0);
    pulseEvt(1'b1, 3'd2, 1'b0, 2'd0);
    pulseEvt(1'b1, 3'd3, 1'b0, 2'd0);
    pulseEvt(1'b1, 3'd5, 1'b0, 2'd0);
    pulseEvt(1'b0, 3'd0, 1'b1, 2'd0);
    pulseEvt(1'b0, 3'd0, 1'b1, 2'd1);
    readStatus("R6 overflow flag", 8'h81);
    chk("R4 gap after overflow read", {7'd0, irq}, 8'h00);
    @(negedge clk);
    readStatus("R5 order 2", 8'h02);
    @(negedge clk);
    readStatus("R5 order 3", 8'h03);
    @(negedge clk);
    readStatus("R5 order 5", 8'h05);
    @(negedge clk);
    readStatus("R5 order 8", 8'h08);
    @(negedge clk);
    chk("R6 dropped event absent", {7'd0, irq}, 8'h00);
    readStatus("R6 empty", 8'h00);

    // receive data path: release any byte latched earlier
    regRd = 1'b1; regSel = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
    shiftIn = 8'h3C;
    #1 chk("R7 live shift", rdData, 8'h3C);
    shiftIn = 8'h5A;
    #1 chk("R7 live shift change", rdData, 8'h5A);
    shiftIn = 8'hA5;
    pulseEvt(1'b1, 3'd4, 1'b0, 2'd0);
    @(negedge clk);
    shiftIn = 8'h11;
    #1 chk("R7 latched byte", rdData, 8'hA5);
    readStatus("R2 rx code", 8'h04);
    regSel = 1'b1;
    #1 chk("R7 latch kept after status read", rdData, 8'hA5);
    regRd = 1'b1;
    #1 chk("R8 rx read value", rdData, 8'hA5);
    @(negedge clk);
    regRd = 1'b0;
    #1 chk("R8 live after rx read", rdData, 8'h11);
    regSel = 1'b0;

    // R1 again: reset clears a shown code
    pulseEvt(1'b0, 3'd0, 1'b1, 2'd1);
    @(negedge clk);
    chk("R2 pre-reset code", rdData, 8'h09);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);
    chk("R1 status after reset", rdData, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule